// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Compare Logic

This block sits on the device side of an asynchronous DRAM strobe interface. It samples the row strobe, the column strobe and the write enable on a local clock and works out the kind of each memory cycle from the order in which the strobes move. One strobe ordering switches the device into a persistent parallel test mode. Two kinds of refresh cycle switch it back to normal operation.

In normal operation the block serves a single data bit. Three column address bits pick one of eight internal bits, both for reads and for writes. In test mode those three column bits are ignored. A read then compresses all eight internal bits into one pass/fail level on the data pin, and a write copies the single input bit into all eight locations. The data pin is modelled as an output value plus an output enable. The storage array is outside the block. The block receives the eight addressed bits from the array and returns a write strobe, a bit mask and write data.

Top module: `dram_ptest_ctl`

## Requirements
- R1: When the row strobe is first sampled low while the column strobe and write enable are both sampled low, `test_mode` reads 1 from the following clock cycle.
- R2: Once set, `test_mode` stays 1 through any number of idle, read, write or entry cycles until an exit cycle completes.
- R3: When the row strobe is first sampled low with the column strobe low and write enable high (a column-before-row refresh), `test_mode` reads 0 from the following cycle.
- R4: A row cycle that starts with the column strobe high and ends without any column strobe fall (a row-only refresh) clears `test_mode` in the cycle after the row strobe is sampled high again. It does not clear it while the row strobe is still low.
- R5: In a test-mode read, `dq_out` is 1 when the eight bits of `arr_rd_data` are all equal (all 0 or all 1) and 0 otherwise. The value is driven with `dq_oe` = 1 from the cycle after the column strobe fall is sampled.
- R6: The bit index is {col_addr[COL_W-1], col_addr[1], col_addr[0]}, with the top column bit as the index MSB. A normal read returns `arr_rd_data[index]`. In test mode the value of these three bits has no effect on `dq_out`.
- R7: When write enable is low at the sampled column strobe fall (an early write), `dq_oe` stays 0 for the whole cycle. `arr_wr_en` pulses for exactly one cycle, in the cycle after the fall.
- R8: A normal write sets `arr_wr_mask` to a one-hot value at the bit index. A test-mode write sets all eight mask bits. In both cases `arr_wr_data` carries `dq_in` in every bit.
- R9: `dq_oe` drops to 0 in the cycle after either strobe is sampled high.
- R10: While reset is asserted and right after it, `test_mode`, `dq_oe` and `arr_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_addr | input | COL_W | Column address held during the column strobe |
| dq_in | input | 1 | Data pin input value |
| dq_out | output | 1 | Data pin output value |
| dq_oe | output | 1 | Data pin output enable (0 = high impedance) |
| test_mode | output | 1 | Parallel test mode latched |
| arr_rd_data | input | FOLD | Eight internal bits of the addressed group |
| arr_wr_en | output | 1 | One-cycle array write strobe |
| arr_wr_mask | output | FOLD | Bits of the group to write |
| arr_wr_data | output | FOLD | Write data per bit |

## Verification
Each result comes from exactly one register stage. A mode change shows on `test_mode` one cycle after the sample at which the row strobe falls, and for a row-only refresh one cycle after the sample at which it rises. Read data and the output enable appear one cycle after the sampled column strobe fall. The write strobe pulses in that same cycle, and the enable drops one cycle after either strobe rises. The bench drives inputs on falling clock edges and samples outputs on the falling edge after the single rising edge that should produce the result. The bench also checks `test_mode` in the middle of a row-only refresh, so that an exit taken too early is caught.

// File: rtl/dram_ptest_pkg.sv
package dram_ptest_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE    = 2'd0,
      CYC_ACCESS  = 2'd1,
      CYC_REFRESH = 2'd2
   } cyc_kind_e;

   typedef struct packed {
      logic ras_fall;
      logic ras_rise;
      logic cas_fall;
   } strobe_ev_t;

endpackage

// File: rtl/dram_ptest_edge.sv
module dram_ptest_edge
   import dram_ptest_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ras_n,
   input  logic       cas_n,
   output strobe_ev_t ev
);

   logic ras_q;
   logic cas_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q <= 1'b1;
         cas_q <= 1'b1;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
      end
   end

   always_comb begin
      ev.ras_fall = ras_q & ~ras_n;
      ev.ras_rise = ~ras_q & ras_n;
      ev.cas_fall = cas_q & ~cas_n;
   end

endmodule

// File: rtl/dram_ptest_mode.sv
module dram_ptest_mode
   import dram_ptest_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  strobe_ev_t ev,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   output logic       test_mode,
   output logic       access_fall
);

   cyc_kind_e cyc_q;
   logic      cas_seen_q;

   // a column strobe fall inside a row cycle that began with the column strobe high
   assign access_fall = ev.cas_fall & ~ras_n & (cyc_q == CYC_ACCESS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q      <= CYC_IDLE;
         cas_seen_q <= 1'b0;
         test_mode  <= 1'b0;
      end else begin
         if (ev.ras_fall) begin
            cas_seen_q <= 1'b0;
            if (!cas_n) begin
               cyc_q     <= CYC_REFRESH;
               test_mode <= ~we_n;
            end else begin
               cyc_q <= CYC_ACCESS;
            end
         end else if (ev.ras_rise) begin
            cyc_q <= CYC_IDLE;
            if (cyc_q == CYC_ACCESS && !cas_seen_q) begin
               test_mode <= 1'b0;
            end
         end else if (access_fall) begin
            cas_seen_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dram_ptest_dq.sv
module dram_ptest_dq #(
   parameter int COL_W = 11,
   parameter int FOLD  = 8,
   localparam int SEL_W = $clog2(FOLD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             access_fall,
   input  logic             test_mode,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [COL_W-1:0] col_addr,
   input  logic [FOLD-1:0]  arr_rd_data,
   input  logic             dq_in,
   output logic             dq_out,
   output logic             dq_oe,
   output logic             arr_wr_en,
   output logic [FOLD-1:0]  arr_wr_mask,
   output logic [FOLD-1:0]  arr_wr_data
);

   logic [SEL_W-1:0] sel;
   logic [FOLD-1:0]  sel_oh;
   logic             all_eq;
   logic             pick;

   // index: top column bit as MSB, then the lowest SEL_W-1 column bits
   generate
      if (SEL_W > 1) begin : g_sel_multi
         assign sel = {col_addr[COL_W-1], col_addr[SEL_W-2:0]};
      end else begin : g_sel_single
         assign sel = col_addr[COL_W-1];
      end
      for (genvar i = 0; i < FOLD; i++) begin : g_oh
         assign sel_oh[i] = (sel == SEL_W'(i));
      end
   endgenerate

   assign all_eq = (&arr_rd_data) | ~(|arr_rd_data);
   assign pick   = arr_rd_data[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_out      <= 1'b0;
         dq_oe       <= 1'b0;
         arr_wr_en   <= 1'b0;
         arr_wr_mask <= '0;
         arr_wr_data <= '0;
      end else begin
         arr_wr_en <= 1'b0;
         if (cas_n || ras_n) begin
            dq_oe <= 1'b0;
         end
         if (access_fall) begin
            if (!we_n) begin
               arr_wr_en   <= 1'b1;
               arr_wr_mask <= test_mode ? {FOLD{1'b1}} : sel_oh;
               arr_wr_data <= {FOLD{dq_in}};
            end else begin
               dq_oe  <= 1'b1;
               dq_out <= test_mode ? all_eq : pick;
            end
         end
      end
   end

endmodule

// File: rtl/dram_ptest_ctl.sv
module dram_ptest_ctl
   import dram_ptest_pkg::*;
#(
   parameter int COL_W = 11,
   parameter int FOLD  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [COL_W-1:0] col_addr,
   input  logic             dq_in,
   output logic             dq_out,
   output logic             dq_oe,
   output logic             test_mode,
   input  logic [FOLD-1:0]  arr_rd_data,
   output logic             arr_wr_en,
   output logic [FOLD-1:0]  arr_wr_mask,
   output logic [FOLD-1:0]  arr_wr_data
);

   localparam int SEL_W = $clog2(FOLD);

   generate
      if (FOLD < 2 || (FOLD & (FOLD - 1)) != 0) begin : g_bad_fold
         $error("FOLD must be a power of two of at least 2");
      end
      if (COL_W <= SEL_W) begin : g_bad_col
         $error("COL_W must exceed the index width");
      end
   endgenerate

   strobe_ev_t ev;
   logic       access_fall;

   dram_ptest_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .ev    (ev)
   );

   dram_ptest_mode u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (ev),
      .ras_n       (ras_n),
      .cas_n       (cas_n),
      .we_n        (we_n),
      .test_mode   (test_mode),
      .access_fall (access_fall)
   );

   dram_ptest_dq #(.COL_W(COL_W), .FOLD(FOLD)) u_dq (
      .clk         (clk),
      .rst_n       (rst_n),
      .access_fall (access_fall),
      .test_mode   (test_mode),
      .ras_n       (ras_n),
      .cas_n       (cas_n),
      .we_n        (we_n),
      .col_addr    (col_addr),
      .arr_rd_data (arr_rd_data),
      .dq_in       (dq_in),
      .dq_out      (dq_out),
      .dq_oe       (dq_oe),
      .arr_wr_en   (arr_wr_en),
      .arr_wr_mask (arr_wr_mask),
      .arr_wr_data (arr_wr_data)
   );

endmodule

// File: rtl/dram_ptest_chk.sv
module dram_ptest_chk #(
   parameter int FOLD = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ras_n,
   input logic            cas_n,
   input logic            we_n,
   input logic            dq_in,
   input logic            dq_out,
   input logic            dq_oe,
   input logic            test_mode,
   input logic [FOLD-1:0] arr_rd_data,
   input logic            arr_wr_en,
   input logic [FOLD-1:0] arr_wr_mask,
   input logic [FOLD-1:0] arr_wr_data
);

   p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !cas_n && !we_n) |=> test_mode);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !$fell(ras_n) && !$rose(ras_n)) |=> test_mode);

   p_cbr_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !cas_n && we_n) |=> !test_mode);

   p_test_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !ras_n && !$past(ras_n) && we_n && test_mode)
      |=> (dq_oe && dq_out == ((&$past(arr_rd_data)) || !(|$past(arr_rd_data)))));

   p_early_write_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !ras_n && !$past(ras_n) && !we_n) |=> (!dq_oe && arr_wr_en));

   p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_en |=> !arr_wr_en);

   p_test_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !ras_n && !$past(ras_n) && !we_n && test_mode)
      |=> (&arr_wr_mask && arr_wr_data == {FOLD{$past(dq_in)}}));

   p_norm_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_wr_en && !test_mode) |-> $onehot0(arr_wr_mask) && $countones(arr_wr_mask) == 1);

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n || ras_n) |=> !dq_oe);

endmodule

bind dram_ptest_ctl dram_ptest_chk #(.FOLD(FOLD)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n),
   .dq_in       (dq_in),
   .dq_out      (dq_out),
   .dq_oe       (dq_oe),
   .test_mode   (test_mode),
   .arr_rd_data (arr_rd_data),
   .arr_wr_en   (arr_wr_en),
   .arr_wr_mask (arr_wr_mask),
   .arr_wr_data (arr_wr_data)
);

// File: tb/dram_ptest_ctl_tb.sv
module dram_ptest_ctl_tb_top;

   localparam int COL_W = 11;
   localparam int FOLD  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ras_n = 1'b1;
   logic             cas_n = 1'b1;
   logic             we_n = 1'b1;
   logic [COL_W-1:0] col_addr = '0;
   logic             dq_in = 1'b0;
   logic             dq_out;
   logic             dq_oe;
   logic             test_mode;
   logic [FOLD-1:0]  arr_rd_data;
   logic             arr_wr_en;
   logic [FOLD-1:0]  arr_wr_mask;
   logic [FOLD-1:0]  arr_wr_data;

   logic [FOLD-1:0]  mem [4];
   int               n_checks = 0;
   int               n_errs = 0;
   bit               done = 1'b0;

   always #5 clk = ~clk;

   dram_ptest_ctl #(.COL_W(COL_W), .FOLD(FOLD)) dut_i (
      .clk (clk), .rst_n (rst_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .col_addr (col_addr), .dq_in (dq_in), .dq_out (dq_out), .dq_oe (dq_oe),
      .test_mode (test_mode), .arr_rd_data (arr_rd_data), .arr_wr_en (arr_wr_en),
      .arr_wr_mask (arr_wr_mask), .arr_wr_data (arr_wr_data)
   );

   // stand-in storage: group chosen by column bits 3:2
   assign arr_rd_data = mem[col_addr[3:2]];

   always @(posedge clk) begin
      if (arr_wr_en) begin
         for (int i = 0; i < FOLD; i++) begin
            if (arr_wr_mask[i]) mem[col_addr[3:2]][i] <= arr_wr_data[i];
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd_cycle(input logic [COL_W-1:0] col, input logic exp, input string tag);
      @(negedge clk) ras_n = 1'b0;
      @(negedge clk) begin col_addr = col; we_n = 1'b1; cas_n = 1'b0; end
      @(negedge clk);
      check({tag, " dq_oe"}, 32'(dq_oe), 32'd1);
      check({tag, " dq_out"}, 32'(dq_out), 32'(exp));
      cas_n = 1'b1;
      @(negedge clk);
      check("R9 release after column strobe", 32'(dq_oe), 32'd0);
      ras_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_cycle(input logic [COL_W-1:0] col, input logic bitv, input string tag);
      @(negedge clk) ras_n = 1'b0;
      @(negedge clk) begin col_addr = col; we_n = 1'b0; dq_in = bitv; end
      @(negedge clk) cas_n = 1'b0;
      @(negedge clk);
      check({tag, " R7 hi-z at write"}, 32'(dq_oe), 32'd0);
      check({tag, " R7 write strobe"}, 32'(arr_wr_en), 32'd1);
      @(negedge clk);
      check({tag, " R7 single pulse"}, 32'(arr_wr_en), 32'd0);
      check({tag, " R7 hi-z later"}, 32'(dq_oe), 32'd0);
      cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic enter_tm();
      @(negedge clk) begin cas_n = 1'b0; we_n = 1'b0; end
      @(negedge clk) ras_n = 1'b0;
      @(negedge clk);
      check("R1 entry", 32'(test_mode), 32'd1);
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic test_reset();
      check("R10 test_mode", 32'(test_mode), 32'd0);
      check("R10 dq_oe", 32'(dq_oe), 32'd0);
      check("R10 wr_en", 32'(arr_wr_en), 32'd0);
   endtask

   task automatic test_normal();
      // index {col10,col1,col0} = 3'b101 -> bit 5
      wr_cycle(11'h401, 1'b1, "R8 normal write");
      check("R8 one-hot mask", 32'(mem[0]), 32'h20);
      rd_cycle(11'h401, 1'b1, "R6 normal read bit5");
      rd_cycle(11'h000, 1'b0, "R6 normal read bit0");
   endtask

   task automatic test_enter_hold();
      enter_tm();
      idle(5);
      check("R2 hold idle", 32'(test_mode), 32'd1);
   endtask

   task automatic test_tm_data();
      wr_cycle(11'h004, 1'b1, "R8 test write");
      check("R8 replicate", 32'(mem[1]), 32'hFF);
      check("R2 hold after write", 32'(test_mode), 32'd1);
      rd_cycle(11'h004, 1'b1, "R5 all ones");
      rd_cycle(11'h407, 1'b1, "R6 ignored bits");
      rd_cycle(11'h000, 1'b0, "R5 mixed group");
      wr_cycle(11'h401, 1'b0, "R8 test write zero");
      check("R8 replicate zero", 32'(mem[0]), 32'h00);
      rd_cycle(11'h000, 1'b1, "R5 all zeros");
   endtask

   task automatic test_ras_only_exit();
      @(negedge clk) ras_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R4 no exit while row low", 32'(test_mode), 32'd1);
      ras_n = 1'b1;
      @(negedge clk);
      check("R4 row-only exit", 32'(test_mode), 32'd0);
   endtask

   task automatic test_mixed_then_cbr();
      // clear bit 2 of group 1 (col 0x006 -> index 2)
      wr_cycle(11'h006, 1'b0, "R8 normal clear");
      check("R8 one-hot clear", 32'(mem[1]), 32'hFB);
      rd_cycle(11'h007, 1'b1, "R6 normal read bit3");
      enter_tm();
      rd_cycle(11'h004, 1'b0, "R5 one differing bit");
      @(negedge clk) cas_n = 1'b0;
      @(negedge clk) ras_n = 1'b0;
      @(negedge clk);
      check("R3 refresh exit", 32'(test_mode), 32'd0);
      ras_n = 1'b1; cas_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      for (int g = 0; g < 4; g++) mem[g] = '0;
      idle(3);
      test_reset();
      rst_n = 1'b1;
      idle(2);
      test_reset();
      test_normal();
      test_enter_hold();
      test_tm_data();
      test_ras_only_exit();
      test_mixed_then_cbr();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errs++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule